// File: doc/BRIEF.md
# Bit-Slice Four-Function ALU

This block is a purely combinational arithmetic logic unit of parameterizable width. It is built from identical one-bit slices. Every slice receives one bit of each operand and a set of shared controls. Two of those controls gate the operands to zero: one for the A side and one for the B side. A third control complements the gated A bit. A two-bit function code is decoded into one-hot enables, and the enable that is active places either AND, OR, NOT B or the full-adder sum onto each slice's result bit.

The slices form a ripple-carry chain. The carry-out of slice i feeds the carry-in of slice i+1. The lowest carry-in is an external input, and the carry-out of the top slice is the ALU's carry output. The adder carry is qualified by the add enable, so the carry output reads zero in every non-add function. Subtraction needs no extra hardware. With the A inversion set, carry-in set to 1 and the add function selected, the result is B minus A.

Top module: `bitslice_alu`

## Requirements
- R1: With func_sel = 2'b00 the result is the bitwise AND of the effective operands.
- R2: With func_sel = 2'b01 the result is the bitwise OR of the effective operands.
- R3: With func_sel = 2'b10 the result is the bitwise complement of the effective B operand.
- R4: With func_sel = 2'b11 the value {carry_out, result_out} equals effective A plus effective B plus carry_in, taken as a WIDTH+1 bit sum. Here func_sel[1] is the high select bit.
- R5: When opa_en is 0, every bit of the A operand is taken as 0. When opb_en is 0, every bit of the B operand is taken as 0.
- R6: When opa_inv is 1, the effective A operand is the bitwise complement of the gated A operand. With opa_en = 0 and opa_inv = 1, effective A is therefore all ones.
- R7: In add mode a carry entering at carry_in propagates through every slice. For example, all-ones plus zero with carry_in = 1 gives result 0 and carry_out = 1.
- R8: With both operands enabled, opa_inv = 1, carry_in = 1 and func_sel = 2'b11, result_out equals (B - A) modulo 2^WIDTH. carry_out is then 1 exactly when B >= A.
- R9: For func_sel values 2'b00, 2'b01 and 2'b10, carry_out is 0 whatever the operands and carry_in are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_in | input | WIDTH | Operand A |
| opb_in | input | WIDTH | Operand B |
| opa_en | input | 1 | Passes operand A when 1; forces it to zero when 0 |
| opb_en | input | 1 | Passes operand B when 1; forces it to zero when 0 |
| opa_inv | input | 1 | Complements the gated A operand |
| func_sel | input | 2 | Function code: 00 AND, 01 OR, 10 NOT B, 11 add |
| carry_in | input | 1 | Carry into the lowest slice |
| result_out | output | WIDTH | Function result |
| carry_out | output | 1 | Carry out of the top slice; zero outside add mode |

## Verification
The block holds no state, so any fault appears at the ports as soon as the inputs settle, on the same vector that triggers it. A decoder that drives the wrong enable gives results from the wrong function, or the OR of two functions. A break in the ripple chain shows only on operand pairs whose carry runs across the broken slice. For this reason the sweep drives every operand pair at a narrow width under every control combination and both carry-in values. It then runs the all-zeros, all-ones and full-length carry cases at the default width.

// File: rtl/alu_pkg.sv
// Shared definitions for the bit-slice ALU.
// Assumes the function code is two bits with the high bit listed first.
package alu_pkg;

    localparam int OP_COUNT = 4;

    // Function codes; the values double as one-hot enable positions.
    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_ADD  = 2'b11
    } alu_fn_e;

endpackage

// File: rtl/alu_fn_decoder.sv
// Two-to-four decoder: turns the function code into one-hot enables.
// Assumes the enable vector is indexed by the alu_fn_e value.
module alu_fn_decoder
    import alu_pkg::*;
(
    input  logic [1:0]          fn_code,
    output logic [OP_COUNT-1:0] fn_onehot
);

    // Raise only the enable picked by the code.
    always_comb begin
        fn_onehot = '0;
        fn_onehot[fn_code] = 1'b1;
    end

endmodule

// File: rtl/alu_slice.sv
// One bit of the ALU. It gates and optionally inverts the operand bits,
// forms AND, OR, NOT B and the full-adder sum, and drives out the
// result whose enable is active. The carry out is qualified by the add
// enable. Assumes fn_en is one-hot.
module alu_slice
    import alu_pkg::*;
(
    input  logic                bit_a,
    input  logic                bit_b,
    input  logic                gate_a,
    input  logic                gate_b,
    input  logic                flip_a,
    input  logic [OP_COUNT-1:0] fn_en,
    input  logic                c_in,
    output logic                bit_y,
    output logic                c_out
);

    logic eff_a;
    logic eff_b;
    logic and_v;
    logic or_v;
    logic notb_v;
    logic sum_v;
    logic maj_v;

    // Operand conditioning: gating first, then optional A inversion.
    always_comb begin
        eff_b = bit_b & gate_b;
        eff_a = (bit_a & gate_a) ^ flip_a;
    end

    // Logic unit and full adder.
    always_comb begin
        and_v  = eff_a & eff_b;
        or_v   = eff_a | eff_b;
        notb_v = ~eff_b;
        sum_v  = eff_a ^ eff_b ^ c_in;
        maj_v  = (eff_a & eff_b) | (c_in & (eff_a ^ eff_b));
    end

    // Enable-gated output: each result is masked by its own enable.
    always_comb begin
        bit_y = (and_v  & fn_en[FN_AND])
              | (or_v   & fn_en[FN_OR])
              | (notb_v & fn_en[FN_NOTB])
              | (sum_v  & fn_en[FN_ADD]);
        c_out = maj_v & fn_en[FN_ADD];
    end

endmodule

// File: rtl/bitslice_alu.sv
// WIDTH-bit four-function ALU made of chained one-bit slices with a
// ripple carry. Purely combinational. Assumes WIDTH >= 1. Setting
// opa_inv=1, carry_in=1 and the add code gives B minus A.
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
)(
    input  logic [WIDTH-1:0] opa_in,
    input  logic [WIDTH-1:0] opb_in,
    input  logic             opa_en,
    input  logic             opb_en,
    input  logic             opa_inv,
    input  logic [1:0]       func_sel,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result_out,
    output logic             carry_out
);

    localparam int CHAIN_LEN = WIDTH + 1;

    logic [OP_COUNT-1:0]  fn_en_w;
    logic [CHAIN_LEN-1:0] ripple;

    alu_fn_decoder dec_i (
        .fn_code   (func_sel),
        .fn_onehot (fn_en_w)
    );

    // Carry chain entry point.
    assign ripple[0] = carry_in;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
        alu_slice slice_i (
            .bit_a  (opa_in[gi]),
            .bit_b  (opb_in[gi]),
            .gate_a (opa_en),
            .gate_b (opb_en),
            .flip_a (opa_inv),
            .fn_en  (fn_en_w),
            .c_in   (ripple[gi]),
            .bit_y  (result_out[gi]),
            .c_out  (ripple[gi+1])
        );
    end

    // Carry out of the top slice.
    assign carry_out = ripple[WIDTH];

    // Word-level reference operands, used only by the checks below.
    logic [WIDTH-1:0] ref_a;
    logic [WIDTH-1:0] ref_b;
    logic [WIDTH:0]   ref_sum;

    // Build the reference operands and sum for the checks.
    always_comb begin
        ref_b   = opb_en ? opb_in : '0;
        ref_a   = (opa_en ? opa_in : '0) ^ {WIDTH{opa_inv}};
        ref_sum = {1'b0, ref_a} + {1'b0, ref_b} + {{WIDTH{1'b0}}, carry_in};
    end

    // Cross-check the slice outputs against the word-level reference.
    always_comb begin
        a_r1_onehot_decode: assert ($onehot(fn_en_w))
            else $error("decoder enables not one-hot");
        if (func_sel != FN_ADD) begin
            a_r9_carry_idle: assert (carry_out == 1'b0)
                else $error("carry_out set outside add mode");
        end
        if (func_sel == FN_ADD) begin
            a_r4_add_word: assert ({carry_out, result_out} == ref_sum)
                else $error("add result mismatch");
        end
        if (func_sel == FN_NOTB) begin
            a_r3_notb_word: assert (result_out == ~ref_b)
                else $error("NOT B result mismatch");
        end
        if (!opa_en && !opb_en && !opa_inv && func_sel != FN_NOTB && func_sel != FN_ADD) begin
            a_r5_gated_zero: assert (result_out == '0)
                else $error("gated operands not zero");
        end
    end

endmodule

// File: tb/bitslice_alu_tb_top.sv
// Testbench: exhaustive sweep at 4 bits, corner cases at 8 bits.
module bitslice_alu_tb_top;

    localparam int NW = 4;
    localparam int WW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [NW-1:0] a4, b4, y4;
    logic [WW-1:0] a8, b8, y8;
    logic ena, enb, inv, cin, co4, co8;
    logic [1:0] fsel;

    bitslice_alu #(.WIDTH(NW)) dut_i (
        .opa_in(a4), .opb_in(b4), .opa_en(ena), .opb_en(enb), .opa_inv(inv),
        .func_sel(fsel), .carry_in(cin), .result_out(y4), .carry_out(co4)
    );

    bitslice_alu #(.WIDTH(WW)) dut_w_i (
        .opa_in(a8), .opb_in(b8), .opa_en(ena), .opb_en(enb), .opa_inv(inv),
        .func_sel(fsel), .carry_in(cin), .result_out(y8), .carry_out(co8)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Drive one 8-bit vector and compare.
    task automatic corner(input string req, input logic [7:0] a, input logic [7:0] b,
                          input logic ea, input logic eb, input logic iv,
                          input logic [1:0] f, input logic c,
                          input logic [7:0] ey, input logic eco);
        @(posedge clk);
        a8 = a; b8 = b; ena = ea; enb = eb; inv = iv; fsel = f; cin = c;
        #1;
        check(req, {23'd0, co8, y8}, {23'd0, eco, ey});
    endtask

    initial begin
        a4 = '0; b4 = '0; a8 = '0; b8 = '0;
        ena = 1'b0; enb = 1'b0; inv = 1'b0; cin = 1'b0; fsel = 2'b00;
        @(posedge clk);
        #1;
        // Idle inputs: AND of zeros gives zero, no carry.
        check("R1 idle", {co8, y8}, 0);

        // Exhaustive sweep at 4 bits.
        for (int f = 0; f < 4; f++) begin
            for (int ctl = 0; ctl < 16; ctl++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        int xa, xb, ey, eco;
                        @(posedge clk);
                        fsel = f[1:0];
                        ena = ctl[0]; enb = ctl[1]; inv = ctl[2]; cin = ctl[3];
                        a4 = a[NW-1:0]; b4 = b[NW-1:0];
                        xa = ctl[0] ? a : 0;
                        if (ctl[2]) xa = xa ^ 15;       // R6 inversion
                        xb = ctl[1] ? b : 0;            // R5 gating
                        eco = 0;                        // R9 non-add carry
                        case (f)
                            0: ey = xa & xb;
                            1: ey = xa | xb;
                            2: ey = xb ^ 15;
                            default: begin
                                ey  = (xa + xb + ctl[3]) & 15;
                                eco = ((xa + xb + ctl[3]) >> 4) & 1;
                            end
                        endcase
                        #1;
                        case (f)
                            0: check("R1/R5/R6 AND", {co4, y4}, eco * 16 + ey);
                            1: check("R2/R5/R6 OR", {co4, y4}, eco * 16 + ey);
                            2: check("R3/R9 NOTB", {co4, y4}, eco * 16 + ey);
                            default: check("R4/R7 ADD", {co4, y4}, eco * 16 + ey);
                        endcase
                        if (f == 3 && ctl == 4'b1111) begin
                            // R8: B minus A
                            check("R8 SUB", {co4, y4}, ((b >= a) ? 16 : 0) + ((b - a) & 15));
                        end
                    end
                end
            end
        end

        // Corner cases at the default width.
        corner("R4 zeros",       8'h00, 8'h00, 1, 1, 0, 2'b11, 0, 8'h00, 0);
        corner("R7 ripple all",  8'hFF, 8'h00, 1, 1, 0, 2'b11, 1, 8'h00, 1);
        corner("R7 ones+1",      8'hFF, 8'h01, 1, 1, 0, 2'b11, 0, 8'h00, 1);
        corner("R4 ones+ones",   8'hFF, 8'hFF, 1, 1, 0, 2'b11, 1, 8'hFF, 1);
        corner("R8 0-1",         8'h01, 8'h00, 1, 1, 1, 2'b11, 1, 8'hFF, 0);
        corner("R8 equal",       8'h5A, 8'h5A, 1, 1, 1, 2'b11, 1, 8'h00, 1);
        corner("R1 and",         8'hF0, 8'h3C, 1, 1, 0, 2'b00, 1, 8'h30, 0);
        corner("R2 or",          8'hF0, 8'h0C, 1, 1, 0, 2'b01, 1, 8'hFC, 0);
        corner("R3 notb",        8'hFF, 8'hA5, 1, 1, 0, 2'b10, 1, 8'h5A, 0);
        corner("R6 a ones",      8'h00, 8'h33, 0, 1, 1, 2'b00, 0, 8'h33, 0);
        corner("R5 b gated",     8'hFF, 8'hFF, 1, 0, 0, 2'b01, 0, 8'hFF, 0);
        corner("R9 or no carry", 8'hFF, 8'hFF, 1, 1, 0, 2'b01, 1, 8'hFF, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule